// File: doc/BRIEF.md
# Dispatch Group Slot Allocator

This block decides, one candidate instruction at a time, whether the candidate may join the dispatch group being assembled. A scheduler presents the candidate's class code with a valid strobe and reads back a combinational verdict in the same cycle. The verdict is accept, hazard (the group must be closed before this candidate can go), or no-op (a filler no-op must be issued first). The block keeps the group state: the number of slots used, the load on each execution resource, and whether the count register has been written in this group.

The scheduler commits an accepted candidate with the issue strobe. It spends a slot on a no-op with the advance strobe. A start-of-block strobe clears the group. Decoding instructions into classes and choosing which candidate to offer are left to the surrounding scheduler.

Class codes (4 bits): 0 fixed-point, 1 fixed-point lead-only (integer divide), 2 load, 3 store, 4 float, 5 condition-register op, 6 special-register op, 7 vector ALU, 8 vector permute, 9 branch, 10 pseudo. Codes 11 to 15 are handled as pseudo. Verdict codes (2 bits): 0 accept, 1 hazard, 2 no-op.

Top module: `dga_slot_alloc`

## Requirements
- R1: A group holds up to SLOTS (default 5) slots. `slot_cnt_o` gives the number used. When a commit or an advance would fill the last slot, the group closes and `slot_cnt_o` returns to 0 on the next cycle.
- R2: Classes 0 and 1 share a cap of PAIR_CAP (default 2). Loads and stores (2, 3) share a cap of PAIR_CAP. Floats (4) have a cap of PAIR_CAP. A candidate whose own cap is reached gets verdict 1.
- R3: Classes 5, 6, 7 and 8 each allow one op per group. A second op of the same class gets verdict 1. Each class checks only its own resource.
- R4: When SLOTS-1 slots are used, any candidate other than a branch (9) gets verdict 1, and a branch is accepted.
- R5: Committing a branch closes the group at once: `slot_cnt_o` is 0 on the next cycle, whatever the count before.
- R6: Classes 1, 5 and 6 are accepted only when `slot_cnt_o` is 0. Otherwise they get verdict 1.
- R7: After a candidate committed with `cand_ctr_wr_i` high in the current group, a branch with `cand_ctr_br_i` high gets verdict 2. A branch without that flag is still accepted.
- R8: Pseudo classes (10 to 15) always get verdict 0. Issuing one changes no slot or resource state.
- R9: With no commit in the cycle, `advance_i` adds one slot and closes the group on reaching SLOTS. In a cycle with a commit, `advance_i` is ignored.
- R10: `blk_start_i` clears the group on the next cycle and overrides a commit or an advance in the same cycle.
- R11: With `cand_valid_i` low the verdict is 0, and `issue_i` has no effect.
- R12: `issue_i` commits only a candidate whose verdict is 0. An issue against verdict 1 or 2 leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_start_i | input | 1 | Start of block; clears the group |
| cand_valid_i | input | 1 | Candidate present |
| cand_class_i | input | 4 | Candidate class code |
| cand_ctr_wr_i | input | 1 | Candidate writes the count register |
| cand_ctr_br_i | input | 1 | Candidate branches through the count register |
| issue_i | input | 1 | Commit the candidate |
| advance_i | input | 1 | Spend one slot on a no-op |
| verdict_o | output | 2 | 0 accept, 1 hazard, 2 no-op |
| slot_cnt_o | output | $clog2(SLOTS) | Slots used in the current group |

## Verification
The bench goes after the interplay of rules at the boundaries:
- A non-branch candidate in the last slot. A design that ignored the branch-only rule would let a fifth non-branch op in and overflow the group.
- A lead-only class offered behind one committed op. Getting this wrong would accept a divide or register move mid-group.
- A branch through the count register after a count write. Returning a plain hazard here instead of a no-op would close groups needlessly.
- Issue against a refused candidate, and advance together with a commit. Getting either wrong would let the slot count drift from the reference, and the per-cycle comparison would catch it within a cycle.
- Random traffic with block starts mixed in, to cover cap interactions across resources.

// File: rtl/dga_pkg.sv
package dga_pkg;

  typedef enum logic [3:0] {
    CLS_FX      = 4'd0,
    CLS_FX_LEAD = 4'd1,
    CLS_LOAD    = 4'd2,
    CLS_STORE   = 4'd3,
    CLS_FLOAT   = 4'd4,
    CLS_CRF     = 4'd5,
    CLS_SPREG   = 4'd6,
    CLS_VALU    = 4'd7,
    CLS_VPERM   = 4'd8,
    CLS_BRANCH  = 4'd9,
    CLS_PSEUDO  = 4'd10
  } iclass_e;

  typedef enum logic [1:0] {
    VD_ACCEPT = 2'd0,
    VD_HAZARD = 2'd1,
    VD_NOOP   = 2'd2
  } verdict_e;

  // resource indices: pair-capped first, single-capped after
  localparam int RES_FX    = 0;
  localparam int RES_LS    = 1;
  localparam int RES_FP    = 2;
  localparam int RES_CRF   = 3;
  localparam int RES_SPREG = 4;
  localparam int RES_VALU  = 5;
  localparam int RES_VPERM = 6;
  localparam int NUM_RES   = 7;
  localparam int NUM_PAIR  = 3;

  function automatic logic is_pseudo(logic [3:0] c);
    return c >= 4'(CLS_PSEUDO);
  endfunction

  function automatic logic is_lead_only(logic [3:0] c);
    return (c == 4'(CLS_FX_LEAD)) || (c == 4'(CLS_CRF)) || (c == 4'(CLS_SPREG));
  endfunction

  function automatic logic [NUM_RES-1:0] res_mask(logic [3:0] c);
    logic [NUM_RES-1:0] m;
    m = '0;
    case (c)
      4'(CLS_FX), 4'(CLS_FX_LEAD): m[RES_FX]    = 1'b1;
      4'(CLS_LOAD), 4'(CLS_STORE): m[RES_LS]    = 1'b1;
      4'(CLS_FLOAT):               m[RES_FP]    = 1'b1;
      4'(CLS_CRF):                 m[RES_CRF]   = 1'b1;
      4'(CLS_SPREG):               m[RES_SPREG] = 1'b1;
      4'(CLS_VALU):                m[RES_VALU]  = 1'b1;
      4'(CLS_VPERM):               m[RES_VPERM] = 1'b1;
      default:                     m = '0;
    endcase
    return m;
  endfunction

  function automatic int res_cap(int r, int pair_cap);
    return (r < NUM_PAIR) ? pair_cap : 1;
  endfunction

endpackage

// File: rtl/dga_res_cnt.sv
module dga_res_cnt #(
  parameter int CAP = 2,
  localparam int CW = (CAP < 2) ? 1 : $clog2(CAP + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic full_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (inc_i && !full_o)   cnt_q <= cnt_q + CW'(1);
  end

  assign full_o = (cnt_q >= CW'(CAP));

endmodule

// File: rtl/dga_state.sv
module dga_state
  import dga_pkg::*;
#(
  parameter int SLOTS    = 5,
  parameter int PAIR_CAP = 2,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               blk_start_i,
  input  logic               commit_i,
  input  logic [3:0]         commit_cls_i,
  input  logic               commit_ctr_wr_i,
  input  logic               advance_i,
  output logic [SW-1:0]      slot_cnt_o,
  output logic [NUM_RES-1:0] res_full_o,
  output logic               ctr_set_o
);

  logic [SW-1:0]      slot_q;
  logic               ctr_q;
  logic               bump;
  logic               last_slot;
  logic               close;
  logic [NUM_RES-1:0] inc_mask;

  assign last_slot = (slot_q == SW'(SLOTS - 1));
  assign bump      = commit_i || advance_i;
  // any close clears every counter; start-of-block acts the same way
  assign close     = blk_start_i
                   || (commit_i && (commit_cls_i == 4'(CLS_BRANCH)))
                   || (bump && last_slot);
  assign inc_mask  = commit_i ? res_mask(commit_cls_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      ctr_q  <= 1'b0;
    end else if (close) begin
      slot_q <= '0;
      ctr_q  <= 1'b0;
    end else begin
      if (bump)                        slot_q <= slot_q + SW'(1);
      if (commit_i && commit_ctr_wr_i) ctr_q  <= 1'b1;
    end
  end

  for (genvar r = 0; r < NUM_RES; r++) begin : g_res
    dga_res_cnt #(.CAP(res_cap(r, PAIR_CAP))) i_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (close),
      .inc_i  (inc_mask[r]),
      .full_o (res_full_o[r])
    );
  end

  assign slot_cnt_o = slot_q;
  assign ctr_set_o  = ctr_q;

endmodule

// File: rtl/dga_verdict.sv
module dga_verdict
  import dga_pkg::*;
#(
  parameter int SLOTS = 5,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic               valid_i,
  input  logic [3:0]         cls_i,
  input  logic               ctr_br_i,
  input  logic [SW-1:0]      slot_cnt_i,
  input  logic [NUM_RES-1:0] res_full_i,
  input  logic               ctr_set_i,
  output verdict_e           verdict_o
);

  logic cap_hit;
  logic lead_bad;
  logic last_bad;
  logic is_br;

  assign is_br    = (cls_i == 4'(CLS_BRANCH));
  assign cap_hit  = |(res_full_i & res_mask(cls_i));
  assign lead_bad = is_lead_only(cls_i) && (slot_cnt_i != '0);
  assign last_bad = (slot_cnt_i == SW'(SLOTS - 1)) && !is_br;

  always_comb begin
    verdict_o = VD_ACCEPT;
    if (valid_i && !is_pseudo(cls_i)) begin
      if (cap_hit || lead_bad || last_bad) verdict_o = VD_HAZARD;
      else if (is_br && ctr_br_i && ctr_set_i) verdict_o = VD_NOOP;
    end
  end

endmodule

// File: rtl/dga_slot_alloc.sv
module dga_slot_alloc
  import dga_pkg::*;
#(
  parameter int SLOTS    = 5,
  parameter int PAIR_CAP = 2,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          blk_start_i,
  input  logic          cand_valid_i,
  input  logic [3:0]    cand_class_i,
  input  logic          cand_ctr_wr_i,
  input  logic          cand_ctr_br_i,
  input  logic          issue_i,
  input  logic          advance_i,
  output logic [1:0]    verdict_o,
  output logic [SW-1:0] slot_cnt_o
);

  logic [NUM_RES-1:0] res_full;
  logic               ctr_set;
  logic               commit;
  verdict_e           verdict;

  dga_verdict #(.SLOTS(SLOTS)) i_verdict (
    .valid_i    (cand_valid_i),
    .cls_i      (cand_class_i),
    .ctr_br_i   (cand_ctr_br_i),
    .slot_cnt_i (slot_cnt_o),
    .res_full_i (res_full),
    .ctr_set_i  (ctr_set),
    .verdict_o  (verdict)
  );

  // only an accepted real instruction consumes a slot; advance yields to it
  assign commit = cand_valid_i && issue_i && (verdict == VD_ACCEPT)
               && !is_pseudo(cand_class_i);

  dga_state #(.SLOTS(SLOTS), .PAIR_CAP(PAIR_CAP)) i_state (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .blk_start_i     (blk_start_i),
    .commit_i        (commit),
    .commit_cls_i    (cand_class_i),
    .commit_ctr_wr_i (cand_ctr_wr_i),
    .advance_i       (advance_i && !commit),
    .slot_cnt_o      (slot_cnt_o),
    .res_full_o      (res_full),
    .ctr_set_o       (ctr_set)
  );

  assign verdict_o = verdict;

endmodule

// File: rtl/dga_slot_alloc_chk.sv
module dga_slot_alloc_chk #(
  parameter int SLOTS = 5,
  localparam int SW = $clog2(SLOTS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          blk_start_i,
  input logic          cand_valid_i,
  input logic [3:0]    cand_class_i,
  input logic          cand_ctr_br_i,
  input logic          issue_i,
  input logic          advance_i,
  input logic [1:0]    verdict_o,
  input logic [SW-1:0] slot_cnt_o
);

  logic real_cand;
  assign real_cand = cand_valid_i && (cand_class_i < 4'd10);

  AST_SLOT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_cnt_o < SW'(SLOTS)); // R1

  AST_LAST_BRANCH_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (real_cand && slot_cnt_o == SW'(SLOTS - 1) && cand_class_i != 4'd9)
      |-> verdict_o == 2'd1); // R4

  AST_BRANCH_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_valid_i && issue_i && cand_class_i == 4'd9 && verdict_o == 2'd0)
      |=> slot_cnt_o == '0); // R5

  AST_LEAD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_valid_i && slot_cnt_o != '0 &&
     (cand_class_i == 4'd1 || cand_class_i == 4'd5 || cand_class_i == 4'd6))
      |-> verdict_o == 2'd1); // R6

  AST_PSEUDO_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_valid_i && cand_class_i >= 4'd10) |-> verdict_o == 2'd0); // R8

  AST_ADVANCE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !(cand_valid_i && issue_i) && !blk_start_i &&
     slot_cnt_o < SW'(SLOTS - 1))
      |=> slot_cnt_o == $past(slot_cnt_o) + SW'(1)); // R9

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_start_i |=> slot_cnt_o == '0); // R10

  AST_IDLE_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cand_valid_i |-> verdict_o == 2'd0); // R11

  AST_REFUSED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_valid_i && issue_i && verdict_o != 2'd0 && !advance_i && !blk_start_i)
      |=> $stable(slot_cnt_o)); // R12

  AST_NOOP_ONLY_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_o == 2'd2) |-> (cand_class_i == 4'd9 && cand_ctr_br_i)); // R7

endmodule

bind dga_slot_alloc dga_slot_alloc_chk #(.SLOTS(SLOTS)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .blk_start_i  (blk_start_i),
  .cand_valid_i (cand_valid_i),
  .cand_class_i (cand_class_i),
  .cand_ctr_br_i(cand_ctr_br_i),
  .issue_i      (issue_i),
  .advance_i    (advance_i),
  .verdict_o    (verdict_o),
  .slot_cnt_o   (slot_cnt_o)
);

// File: tb/test_dga_slot_alloc.sv
`timescale 1ns/1ps
module test_dga_slot_alloc;

  localparam int SLOTS = 5;
  localparam int SW    = $clog2(SLOTS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          blk_start = 1'b0;
  logic          valid = 1'b0;
  logic [3:0]    cls = '0;
  logic          ctr_wr = 1'b0;
  logic          ctr_br = 1'b0;
  logic          issue = 1'b0;
  logic          adv = 1'b0;
  logic [1:0]    verdict;
  logic [SW-1:0] slot_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference state
  int m_slot = 0;
  int m_cnt[7];
  int m_cap[7] = '{2, 2, 2, 1, 1, 1, 1};
  bit m_ctr = 0;

  always #2.5 clk = ~clk;

  dga_slot_alloc i_dga_slot_alloc (
    .clk_i(clk), .rst_ni(rst_n), .blk_start_i(blk_start),
    .cand_valid_i(valid), .cand_class_i(cls), .cand_ctr_wr_i(ctr_wr),
    .cand_ctr_br_i(ctr_br), .issue_i(issue), .advance_i(adv),
    .verdict_o(verdict), .slot_cnt_o(slot_cnt)
  );

  function automatic int res_idx(int c);
    case (c)
      0, 1: return 0;
      2, 3: return 1;
      4: return 2;
      5: return 3;
      6: return 4;
      7: return 5;
      8: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic void m_clear();
    m_slot = 0;
    m_ctr  = 0;
    foreach (m_cnt[i]) m_cnt[i] = 0;
  endfunction

  function automatic int ref_verdict(output string tag);
    int r;
    tag = "R1";
    if (!valid) begin tag = "R11"; return 0; end
    if (cls >= 10) begin tag = "R8"; return 0; end
    r = res_idx(int'(cls));
    if (r >= 0 && m_cnt[r] >= m_cap[r]) begin tag = (r < 3) ? "R2" : "R3"; return 1; end
    if ((cls == 1 || cls == 5 || cls == 6) && m_slot != 0) begin tag = "R6"; return 1; end
    if (m_slot == SLOTS - 1 && cls != 9) begin tag = "R4"; return 1; end
    if (cls == 9 && ctr_br && m_ctr) begin tag = "R7"; return 2; end
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive after negedge, check verdict, clock, update model, check slot count
  task automatic step(bit v, int c, bit wr, bit br, bit is, bit ad, bit st);
    string vt;
    string st_tag;
    int    ev;
    valid = v; cls = 4'(c); ctr_wr = wr; ctr_br = br;
    issue = is; adv = ad; blk_start = st;
    #1;
    ev = ref_verdict(vt);
    check(vt, int'(verdict), ev);
    if (st) begin
      st_tag = "R10"; m_clear();
    end else if (v && is && ev == 0 && c < 10) begin
      if (c == 9) begin st_tag = "R5"; m_clear(); end
      else begin
        st_tag = "R1";
        if (res_idx(c) >= 0) m_cnt[res_idx(c)]++;
        if (wr) m_ctr = 1;
        m_slot++;
        if (m_slot == SLOTS) m_clear();
      end
    end else if (ad) begin
      st_tag = "R9";
      m_slot++;
      if (m_slot == SLOTS) m_clear();
    end else if (v && is && c >= 10) st_tag = "R8";
    else if (v && is) st_tag = "R12";
    else st_tag = "R11";
    @(posedge clk);
    @(negedge clk);
    check(st_tag, int'(slot_cnt), m_slot);
  endtask

  task automatic iss(int c);           step(1, c, 0, 0, 1, 0, 0); endtask
  task automatic probe(int c, bit br); step(1, c, 0, br, 0, 0, 0); endtask
  task automatic new_blk();            step(0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    foreach (m_cnt[i]) m_cnt[i] = 0;
    #(5.0 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R11", int'(slot_cnt), 0);                 // reset state
    step(0, 0, 0, 0, 1, 0, 0);                       // R11 issue without valid
    // R2 fixed-point pair cap
    iss(0); iss(0); probe(0, 0); probe(1, 0);
    new_blk();
    // R2 load/store shared cap, float independent
    iss(2); iss(3); probe(2, 0); iss(4); new_blk();
    // R3 single caps and own-resource independence
    iss(5); probe(5, 0); iss(7); probe(7, 0); iss(8); probe(8, 0); new_blk();
    // R6 lead-only classes behind an op
    iss(0); probe(6, 0); probe(5, 0); probe(1, 0); new_blk();
    // R4 last slot branch only, R5 branch close
    iss(0); iss(2); iss(4); iss(7); probe(4, 0); probe(3, 0); iss(9);
    // R5 early branch close
    iss(2); iss(9);
    // R7 count write then branch through it
    step(1, 6, 1, 0, 1, 0, 0);
    probe(9, 1); probe(9, 0); step(1, 9, 0, 1, 1, 0, 0);   // R12 refused issue
    iss(9);
    // R8 pseudo issue
    iss(10); iss(15); step(1, 12, 0, 0, 1, 1, 0);
    // R9 advance wrap and advance ignored on commit
    repeat (5) step(0, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 1, 1, 0);
    // R1 fill with advance at last slot
    iss(2); iss(4); step(0, 0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 0, 1, 0);
    // R10 start overrides commit
    iss(0); step(1, 0, 0, 0, 1, 1, 1);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 100) < 85, $urandom % 16, ($urandom % 4) == 0,
           ($urandom % 2) == 0, ($urandom % 2) == 0, ($urandom % 7) == 0,
           ($urandom % 40) == 0);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule